// File: doc/BRIEF.md
# Shutter and Timestamp-Sync Sequencer

This block runs the fixed ordering that lines up the timestamp counters of several pixel readout units that share one shutter. On a start command it first closes the shutter, then drives a timestamp-zero pulse (T0-sync), then an optional one-cycle chip reset, then holds the shutter closed for a settle gap before letting it reopen. While the shutter is closed around the sync, the front end produces no data.

The block also derives a busy output from two sources: the almost-full flag of the output buffer and a latched halt command. Busy outputs from several units are OR-ed upstream to gate the shared shutter; locally, busy keeps this unit's shutter closed. The T0-sync pulse width and the settle gap are programmed in clock cycles, and each is clamped from below to a minimum parameter (1 cycle and 65 cycles at a 40 MHz reference, i.e. 25 ns and just over 1.6 us).

Top module: `tsync_sequencer`

## Requirements
- R1: While reset is active and on the first cycle after it, shutter_o, tsync_o, chip_rst_o, busy_o and done_o are all 0.
- R2: When no sequence is running, busy_o is 0 and start_i is 0 at a clock edge, shutter_o after that edge equals shutter_req_i sampled at that edge.
- R3: busy_o after an edge is 1 when buf_afull_i was 1 at that edge or the halt latch is set after that edge; halt_set_i sets the latch, halt_clr_i clears it, and set wins when both are 1.
- R4: If busy_o is 1 before an edge, shutter_o is 0 after that edge.
- R5: A start_i accepted at edge k (no sequence running) makes shutter_o 0 from cycle k; cycle k is a closed cycle with tsync_o 0; tsync_o is 1 for exactly P = max(cfg_pulse_i, MIN_PULSE) cycles starting at cycle k+1.
- R6: If rst_en_i was 1 at the accepting edge, chip_rst_o is 1 for exactly one cycle directly after the last tsync_o cycle; otherwise chip_rst_o stays 0.
- R7: After the sync (and reset, if any) the shutter stays closed for G = max(cfg_gap_i, MIN_GAP) cycles; then done_o is 1 for one cycle, during which shutter_o is still 0, and the shutter may reopen at the following edge.
- R8: start_i while a sequence is running is ignored: it neither restarts nor extends the sequence and yields no extra done_o pulse.
- R9: cfg_pulse_i, cfg_gap_i and rst_en_i are taken only at the accepting edge; changes during a sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sync sequence start command |
| shutter_req_i | input | 1 | External shutter request |
| buf_afull_i | input | 1 | Output buffer almost-full flag |
| halt_set_i | input | 1 | Halt command, sets the halt latch |
| halt_clr_i | input | 1 | Resume command, clears the halt latch |
| rst_en_i | input | 1 | Issue chip reset in this sequence |
| cfg_pulse_i | input | CNT_W | Requested T0-sync width in cycles |
| cfg_gap_i | input | CNT_W | Requested settle gap in cycles |
| shutter_o | output | 1 | Gated shutter to the front end |
| tsync_o | output | 1 | Timestamp-zero pulse |
| chip_rst_o | output | 1 | Optional chip reset pulse |
| busy_o | output | 1 | Busy to the upstream OR |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with CNT_W = 8, MIN_PULSE = 2 and MIN_GAP = 65, so a requested pulse of 0 or 1 is visibly clamped while a request of 5 passes through, and a requested gap of 0 is clamped while 70 is kept. The 8-bit configuration keeps each sequence under a hundred cycles, which lets several sequences with and without chip reset, overlapping start commands, mid-sequence configuration changes and busy from both sources fit in a short run.

// File: rtl/tsync_pkg.sv
// Shared types of the shutter / T0-sync sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tsync_pkg;

    // Phases of the sync sequence; IDLE is the only phase with an open shutter.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLOSE  = 3'd1,
        PH_SYNC   = 3'd2,
        PH_CHRST  = 3'd3,
        PH_SETTLE = 3'd4
    } seq_phase_e;

endpackage

// File: rtl/tsync_busy_gen.sv
// Busy generator: ORs the buffer almost-full flag with a halt latch.
// Assumes: halt_set_i / halt_clr_i are single-cycle or level commands in the
// clk domain; set has priority over clear. busy_o is registered.
module tsync_busy_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_afull_i,
    input  logic halt_set_i,
    input  logic halt_clr_i,
    output logic busy_o
);
    logic halt_q;
    logic halt_nxt;
    logic busy_q;

    // Next state of the halt latch, set wins over clear.
    always_comb begin
        if (halt_set_i)      halt_nxt = 1'b1;
        else if (halt_clr_i) halt_nxt = 1'b0;
        else                 halt_nxt = halt_q;
    end

    // Register the halt latch and the combined busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            halt_q <= halt_nxt;
            busy_q <= buf_afull_i | halt_nxt;
        end
    end

    assign busy_o = busy_q;

    // R3: a halt command always shows up as busy one cycle later.
    p_halt_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_set_i |=> busy_o);
    // R3: almost-full always shows up as busy one cycle later.
    p_afull_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_afull_i |=> busy_o);
    // R3: busy drops only when neither source holds it.
    p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_afull_i && !halt_set_i && halt_clr_i) |=> !busy_o);

endmodule

// File: rtl/tsync_seq_fsm.sv
// Sequence engine: close -> T0-sync pulse -> optional chip reset -> settle gap.
// Assumes: cfg values are sampled only at the accepting edge and clamped
// from below to MIN_PULSE / MIN_GAP; MIN_PULSE >= 1 and MIN_GAP >= 1 and both
// fit in CNT_W bits. Start is ignored outside the idle phase.
module tsync_seq_fsm
    import tsync_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MIN_PULSE = 1,
    parameter int MIN_GAP   = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rst_en_i,
    input  logic [CNT_W-1:0] cfg_pulse_i,
    input  logic [CNT_W-1:0] cfg_gap_i,
    output logic             idle_o,
    output logic             tsync_o,
    output logic             chip_rst_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0] MIN_G = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    seq_phase_e       phase_q, phase_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pulse_len_q, gap_len_q;
    logic             rst_en_q;
    logic             done_q;
    logic             accept;
    logic             last_sync, last_gap;

    assign accept    = (phase_q == PH_IDLE) && start_i;
    assign last_sync = (cnt_q == pulse_len_q - ONE);
    assign last_gap  = (cnt_q == gap_len_q - ONE);

    // Phase transition logic.
    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start_i) phase_nxt = PH_CLOSE;
            PH_CLOSE:  phase_nxt = PH_SYNC;
            PH_SYNC:   if (last_sync) phase_nxt = rst_en_q ? PH_CHRST : PH_SETTLE;
            PH_CHRST:  phase_nxt = PH_SETTLE;
            PH_SETTLE: if (last_gap) phase_nxt = PH_IDLE;
            default:   phase_nxt = PH_IDLE;
        endcase
    end

    // Phase register and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            if (phase_nxt != phase_q) cnt_q <= '0;
            else                      cnt_q <= cnt_q + ONE;
        end
    end

    // Capture clamped configuration at the accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_len_q <= MIN_P;
            gap_len_q   <= MIN_G;
            rst_en_q    <= 1'b0;
        end else if (accept) begin
            pulse_len_q <= (cfg_pulse_i < MIN_P) ? MIN_P : cfg_pulse_i;
            gap_len_q   <= (cfg_gap_i   < MIN_G) ? MIN_G : cfg_gap_i;
            rst_en_q    <= rst_en_i;
        end
    end

    // One-cycle done pulse on the first idle cycle after the settle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (phase_q == PH_SETTLE) && last_gap;
    end

    assign idle_o     = (phase_q == PH_IDLE);
    assign tsync_o    = (phase_q == PH_SYNC);
    assign chip_rst_o = (phase_q == PH_CHRST);
    assign done_o     = done_q;

    // R8: a start seen outside idle never returns the engine to the close phase.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && phase_q != PH_SETTLE) |=> phase_q != PH_CLOSE);
    // R5: the sync pulse is always preceded by the close phase.
    p_sync_after_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tsync_o) |-> $past(phase_q) == PH_CLOSE);
    // R6: chip reset lasts exactly one cycle.
    p_chrst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |=> !chip_rst_o);
    // R7: done is a single-cycle pulse seen only in idle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (idle_o ##1 !done_o));
    // R5: pulse length never below the minimum.
    p_pulse_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_len_q >= MIN_P);

endmodule

// File: rtl/tsync_shutter_gate.sv
// Shutter gate: passes the external request only while the sequence engine
// is idle, no start is being accepted and busy is low. Output is registered.
// Assumes: busy_i and idle_i are registered signals of the same clock.
module tsync_shutter_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    input  logic idle_i,
    input  logic start_i,
    output logic shutter_o
);
    logic shutter_q;

    // Register the gated shutter.
    always_ff @(posedge clk) begin
        if (!rst_n) shutter_q <= 1'b0;
        else        shutter_q <= req_i & ~busy_i & idle_i & ~start_i;
    end

    assign shutter_o = shutter_q;

    // R4: busy closes the shutter at the next edge.
    p_busy_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !shutter_o);
    // R2: without a request the shutter is closed at the next edge.
    p_no_req_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !shutter_o);

endmodule

// File: rtl/tsync_sequencer.sv
// Top of the shutter / T0-sync sequencer: wires the busy generator, the
// sequence engine and the shutter gate together.
// Assumes: single clock (40 MHz reference for the default minimums),
// synchronous active-low reset, all inputs synchronous to clk.
module tsync_sequencer #(
    parameter int CNT_W     = 16,
    parameter int MIN_PULSE = 1,
    parameter int MIN_GAP   = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             shutter_req_i,
    input  logic             buf_afull_i,
    input  logic             halt_set_i,
    input  logic             halt_clr_i,
    input  logic             rst_en_i,
    input  logic [CNT_W-1:0] cfg_pulse_i,
    input  logic [CNT_W-1:0] cfg_gap_i,
    output logic             shutter_o,
    output logic             tsync_o,
    output logic             chip_rst_o,
    output logic             busy_o,
    output logic             done_o
);
    logic busy_w;
    logic idle_w;

    tsync_busy_gen u_busy (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_afull_i (buf_afull_i),
        .halt_set_i  (halt_set_i),
        .halt_clr_i  (halt_clr_i),
        .busy_o      (busy_w)
    );

    tsync_seq_fsm #(
        .CNT_W     (CNT_W),
        .MIN_PULSE (MIN_PULSE),
        .MIN_GAP   (MIN_GAP)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rst_en_i    (rst_en_i),
        .cfg_pulse_i (cfg_pulse_i),
        .cfg_gap_i   (cfg_gap_i),
        .idle_o      (idle_w),
        .tsync_o     (tsync_o),
        .chip_rst_o  (chip_rst_o),
        .done_o      (done_o)
    );

    tsync_shutter_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (shutter_req_i),
        .busy_i    (busy_w),
        .idle_i    (idle_w),
        .start_i   (start_i),
        .shutter_o (shutter_o)
    );

    assign busy_o = busy_w;

    // R5: the shutter is never open while T0-sync is driven.
    p_sync_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tsync_o |-> !shutter_o);
    // R6: the shutter is closed during and right after the chip reset.
    p_chrst_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> (!shutter_o ##1 !shutter_o));
    // R7: the shutter is still closed on the done cycle.
    p_done_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !shutter_o);

endmodule

// File: tb/tsync_sequencer_tb_top.sv
// Bench: behavioural reference model compared with the outputs every cycle,
// plus directed checks on reset, clamping, ignored starts and config capture.
module tsync_sequencer_tb_top;
    localparam int CNT_W     = 8;
    localparam int MIN_PULSE = 2;
    localparam int MIN_GAP   = 65;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, req = 0, afull = 0, hset = 0, hclr = 0, rsten = 0;
    logic [CNT_W-1:0] cfg_p = '0, cfg_g = '0;
    logic shutter, tsync, chrst, busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;   // 250 MHz

    tsync_sequencer #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE), .MIN_GAP(MIN_GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shutter_req_i(req),
        .buf_afull_i(afull), .halt_set_i(hset), .halt_clr_i(hclr), .rst_en_i(rsten),
        .cfg_pulse_i(cfg_p), .cfg_gap_i(cfg_g),
        .shutter_o(shutter), .tsync_o(tsync), .chip_rst_o(chrst), .busy_o(busy), .done_o(done));

    // ---------------- reference model ----------------
    bit m_idle = 1, m_halt = 0, m_busy = 0, m_shut = 0, m_done = 0, m_rsten = 0;
    int m_off = 0, m_p = 0, m_g = 0;
    int done_cnt = 0;

    function automatic bit m_sync();
        return !m_idle && m_off >= 1 && m_off <= m_p;
    endfunction
    function automatic bit m_chrst();
        return !m_idle && m_rsten && m_off == m_p + 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_idle = 1; m_halt = 0; m_busy = 0; m_shut = 0; m_done = 0; m_off = 0;
        end else begin
            bit old_busy;
            old_busy = m_busy;
            if (hset) m_halt = 1; else if (hclr) m_halt = 0;
            m_busy = afull | m_halt;
            m_done = 0;
            if (m_idle) begin
                m_shut = req & ~old_busy & ~start;
                if (start) begin
                    m_idle = 0; m_off = 0;
                    m_p = (int'(cfg_p) < MIN_PULSE) ? MIN_PULSE : int'(cfg_p);
                    m_g = (int'(cfg_g) < MIN_GAP) ? MIN_GAP : int'(cfg_g);
                    m_rsten = rsten;
                end
            end else begin
                m_shut = 0;
                if (m_off == m_p + int'(m_rsten) + m_g) begin
                    m_idle = 1; m_done = 1;
                end else m_off++;
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(shutter, m_shut,    "R2/R4 shutter_o");
            chk(busy,    m_busy,    "R3 busy_o");
            chk(tsync,   m_sync(),  "R5 tsync_o");
            chk(chrst,   m_chrst(), "R6 chip_rst_o");
            chk(done,    m_done,    "R7 done_o");
            if (done) done_cnt++;
        end
    end

    // Directed sync-width measurement at the port.
    int sync_run = 0, last_width = 0;
    always @(negedge clk) begin
        if (tsync) sync_run++;
        else if (sync_run != 0) begin last_width = sync_run; sync_run = 0; end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_sim();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1; step(1); start = 0;
    endtask

    task automatic chk_int(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    initial begin
        step(3);
        // R1: outputs low in reset.
        chk(shutter | tsync | chrst | busy | done, 1'b0, "R1 outputs in reset");
        rst_n = 1;
        step(1);
        chk(shutter | tsync | chrst | busy | done, 1'b0, "R1 outputs after reset");
        cmp_en = 1;

        // R2: shutter follows request.
        req = 1; step(3);
        chk(shutter, 1'b1, "R2 shutter open on request");
        req = 0; step(2); req = 1; step(2);

        // R3/R4: almost-full closes the shutter.
        afull = 1; step(4);
        chk(shutter, 1'b0, "R4 shutter closed by afull");
        afull = 0; step(3);

        // R3: halt latch, then simultaneous set and clear (set wins).
        hset = 1; step(1); hset = 0; step(5);
        chk(busy, 1'b1, "R3 halt holds busy");
        hset = 1; hclr = 1; step(1); hset = 0; hclr = 0; step(2);
        chk(busy, 1'b1, "R3 set wins over clear");
        hclr = 1; step(1); hclr = 0; step(3);
        chk(busy, 1'b0, "R3 clear releases busy");

        // Sequence 1: clamped pulse and gap, chip reset, extra start, cfg change.
        cfg_p = 8'd0; cfg_g = 8'd0; rsten = 1;
        pulse_start();
        step(3); pulse_start();            // R8: ignored
        cfg_p = 8'd9; cfg_g = 8'd90; rsten = 0;  // R9: must not matter
        step(4);
        chk_int(last_width, MIN_PULSE, "R5 clamped sync width");
        done_cnt = 0;
        step(80);
        chk_int(done_cnt, 1, "R8 one done pulse despite repeated start");
        step(3);
        chk(shutter, 1'b1, "R7 shutter reopens after sequence");

        // Sequence 2: programmed widths, no chip reset, busy during the sequence.
        cfg_p = 8'd5; cfg_g = 8'd70; rsten = 0;
        pulse_start();
        step(10);
        chk_int(last_width, 5, "R5 programmed sync width");
        afull = 1; step(20); afull = 0;
        step(60);
        // Sequence 3: start while busy (halt), with chip reset.
        hset = 1; step(1); hset = 0;
        cfg_p = 8'd1; cfg_g = 8'd66; rsten = 1;
        pulse_start();
        step(80);
        hclr = 1; step(1); hclr = 0;
        step(10);
        chk(shutter, 1'b1, "R2 shutter reopens after halt released");
        finish_sim();
    end

endmodule